// File: doc/BRIEF.md
# 128-bit Set-Less-Than and Branch Condition Unit

This block compares two 128-bit integers, each presented as a pair of 64-bit words, and returns a one-bit verdict. It first forms the full 128-bit difference `a - b`. The borrow out of the low word is passed into the high word. All six relations are then read from that difference and the operand high words. Equality tests the difference for zero. The signed and unsigned less-than verdicts each come from the top bit of one bitwise formula over the high words, so no wide magnitude comparator is needed. The verdict is placed in bit 0 of a 128-bit result, whose other bits are zero. The same bit is also given on a separate branch-taken pin.

The second operand is either the register pair or a 12-bit immediate. The immediate is sign-extended to 128 bits for every condition, including the unsigned ones. Requests enter on a valid/ready handshake. Results leave on a second valid/ready handshake after one register stage.

Back-pressure rules:
- A request is taken on any rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output stage is empty or is being drained in the same cycle.
- A result whose `out_ready` is low stays unchanged at the outputs until it is accepted.

Top module: `cmp128_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Condition code 3'b000 (equal) gives 1 exactly when both 64-bit words of `a - b` are zero.
- R3: Condition code 3'b001 (not equal) gives 1 exactly when either word of `a - b` is nonzero.
- R4: Condition code 3'b100 gives the signed 128-bit `a < b`. Code 3'b101 gives its inverse, signed `a >= b`.
- R5: Condition code 3'b110 gives the unsigned 128-bit `a < b`. Code 3'b111 gives its inverse, unsigned `a >= b`.
- R6: `result[127:1]` is always zero, and `taken` equals `result[0]`.
- R7: With `use_imm` = 1, `b` is `imm[11:0]` sign-extended to 128 bits. Bit 11 set fills bits 127..12 with ones, even for codes 3'b110 and 3'b111.
- R8: Condition codes 3'b010 and 3'b011 give 0.
- R9: The borrow from the low word is applied to the high word. Example: a = 2^64 and b = 1 is not equal, and is not unsigned-less-than.
- R10: An accepted request appears at `out_valid` on the next edge. Results leave in order. While `out_valid` = 1 and `out_ready` = 0, the result holds and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| a_hi | input | 64 | Operand a, bits 127..64 |
| a_lo | input | 64 | Operand a, bits 63..0 |
| b_hi | input | 64 | Operand b, bits 127..64 |
| b_lo | input | 64 | Operand b, bits 63..0 |
| imm | input | 12 | Immediate second operand |
| use_imm | input | 1 | 1 selects the sign-extended immediate as b |
| cond | input | 3 | Relation select, encoded as in R2 to R5 and R8 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result |
| result | output | 128 | Verdict in bit 0, other bits zero |
| taken | output | 1 | Branch-taken copy of the verdict |

## Verification
The only state is the output-stage valid flag and the stored verdict bit. A fault in either shows at the ports one edge after the request is accepted. A fault in the flag appears as a lost, doubled or stuck result, and the in-order scoreboard catches it at the next transfer. A dropped inter-word borrow, or a wrong bit in a formula, gives a wrong verdict in that same cycle. Operand pairs whose words straddle zero, the sign bit and all-ones expose such faults. A verdict that changes while `out_ready` is low is caught one cycle later.

// File: rtl/cmp128_pkg.sv
package cmp128_pkg;
  typedef enum logic [2:0] {
    CC_EQ  = 3'b000,
    CC_NE  = 3'b001,
    CC_LT  = 3'b100,
    CC_GE  = 3'b101,
    CC_LTU = 3'b110,
    CC_GEU = 3'b111
  } cmp_cond_e;

  typedef struct packed {
    logic lo_zero;
    logic hi_zero;
    logic lt_signed;
    logic lt_unsigned;
  } cmp_flags_t;
endpackage

// File: rtl/cmp128_operand.sv
module cmp128_operand #(
  parameter int HALF_W = 64,
  parameter int IMM_W  = 12
) (
  input  logic [HALF_W-1:0] reg_hi,
  input  logic [HALF_W-1:0] reg_lo,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  output logic [HALF_W-1:0] opnd_hi,
  output logic [HALF_W-1:0] opnd_lo
);
  localparam int FULL_W = 2 * HALF_W;
  localparam int FILL_W = FULL_W - IMM_W;

  logic [FULL_W-1:0] imm_ext;

  // Sign extension applies to every condition, unsigned ones included.
  assign imm_ext = {{FILL_W{imm[IMM_W-1]}}, imm};

  always_comb begin
    if (use_imm) begin
      opnd_hi = imm_ext[FULL_W-1:HALF_W];
      opnd_lo = imm_ext[HALF_W-1:0];
    end else begin
      opnd_hi = reg_hi;
      opnd_lo = reg_lo;
    end
  end
endmodule

// File: rtl/cmp128_sub.sv
module cmp128_sub #(
  parameter int HALF_W = 64
) (
  input  logic [HALF_W-1:0] x_hi,
  input  logic [HALF_W-1:0] x_lo,
  input  logic [HALF_W-1:0] y_hi,
  input  logic [HALF_W-1:0] y_lo,
  output logic [HALF_W-1:0] diff_hi,
  output logic [HALF_W-1:0] diff_lo
);
  logic [HALF_W:0] lo_wide;
  logic            borrow;

  // Low word with one extra bit to catch the borrow out.
  assign lo_wide = {1'b0, x_lo} - {1'b0, y_lo};
  assign diff_lo = lo_wide[HALF_W-1:0];
  assign borrow  = lo_wide[HALF_W];

  // High word consumes the borrow.
  assign diff_hi = x_hi - y_hi - {{(HALF_W-1){1'b0}}, borrow};
endmodule

// File: rtl/cmp128_decide.sv
module cmp128_decide
  import cmp128_pkg::*;
#(
  parameter int HALF_W = 64
) (
  input  logic [HALF_W-1:0] diff_hi,
  input  logic [HALF_W-1:0] diff_lo,
  input  logic [HALF_W-1:0] x_hi,
  input  logic [HALF_W-1:0] y_hi,
  input  logic [2:0]        cond,
  output logic              verdict
);
  localparam int TOP = HALF_W - 1;

  cmp_flags_t        flg;
  logic [HALF_W-1:0] s_word;
  logic [HALF_W-1:0] u_word;

  // Signed: overflow-corrected sign of the high difference word.
  assign s_word = diff_hi ^ ((diff_hi ^ x_hi) & (x_hi ^ y_hi));
  // Unsigned: borrow out of the high word, rebuilt bitwise.
  assign u_word = (~(x_hi ^ y_hi) & diff_hi) | (~x_hi & y_hi);

  assign flg.lo_zero     = (diff_lo == '0);
  assign flg.hi_zero     = (diff_hi == '0);
  assign flg.lt_signed   = s_word[TOP];
  assign flg.lt_unsigned = u_word[TOP];

  always_comb begin
    case (cond)
      CC_EQ:   verdict = flg.lo_zero & flg.hi_zero;
      CC_NE:   verdict = ~(flg.lo_zero & flg.hi_zero);
      CC_LT:   verdict = flg.lt_signed;
      CC_GE:   verdict = ~flg.lt_signed;
      CC_LTU:  verdict = flg.lt_unsigned;
      CC_GEU:  verdict = ~flg.lt_unsigned;
      default: verdict = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmp128_unit.sv
module cmp128_unit
  import cmp128_pkg::*;
#(
  parameter int HALF_W = 64,
  parameter int IMM_W  = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [HALF_W-1:0]     a_hi,
  input  logic [HALF_W-1:0]     a_lo,
  input  logic [HALF_W-1:0]     b_hi,
  input  logic [HALF_W-1:0]     b_lo,
  input  logic [IMM_W-1:0]      imm,
  input  logic                  use_imm,
  input  logic [2:0]            cond,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [2*HALF_W-1:0]   result,
  output logic                  taken
);
  localparam int FULL_W = 2 * HALF_W;

  logic [HALF_W-1:0] op_hi, op_lo, d_hi, d_lo;
  logic              verdict;
  logic              fire;
  logic              vld_q, res_q;
  logic [FULL_W-1:0] a_full, b_full;

  cmp128_operand #(.HALF_W(HALF_W), .IMM_W(IMM_W)) u_opnd (
    .reg_hi(b_hi), .reg_lo(b_lo), .imm(imm), .use_imm(use_imm),
    .opnd_hi(op_hi), .opnd_lo(op_lo)
  );

  cmp128_sub #(.HALF_W(HALF_W)) u_sub (
    .x_hi(a_hi), .x_lo(a_lo), .y_hi(op_hi), .y_lo(op_lo),
    .diff_hi(d_hi), .diff_lo(d_lo)
  );

  cmp128_decide #(.HALF_W(HALF_W)) u_dec (
    .diff_hi(d_hi), .diff_lo(d_lo), .x_hi(a_hi), .y_hi(op_hi),
    .cond(cond), .verdict(verdict)
  );

  assign in_ready = ~vld_q | out_ready;
  assign fire     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= 1'b0;
    end else begin
      if (fire) begin
        vld_q <= 1'b1;
        res_q <= verdict;
      end else if (out_ready) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign out_valid = vld_q;
  assign result    = {{(FULL_W-1){1'b0}}, res_q};
  assign taken     = res_q;

  assign a_full = {a_hi, a_lo};
  assign b_full = {op_hi, op_lo};

  p_eq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cond == CC_EQ |=> res_q == ($past(a_full) == $past(b_full)));

  p_ne_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cond == CC_NE |=> res_q == ($past(a_full) != $past(b_full)));

  p_lt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cond == CC_LT |=> res_q == $past($signed(a_full) < $signed(b_full)));

  p_ltu_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && cond == CC_LTU |=> res_q == $past(a_full < b_full));

  p_unused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (cond == 3'b010 || cond == 3'b011) |=> !res_q);

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res_q));
endmodule

// File: tb/sim_cmp128_unit.sv
module sim_cmp128_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [63:0]  a_hi = '0, a_lo = '0, b_hi = '0, b_lo = '0;
  logic [11:0]  imm = '0;
  logic         use_imm = 1'b0;
  logic [2:0]   cond = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] result;
  logic         taken;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit bp_en = 1'b0;
  bit done  = 1'b0;

  logic  exp_q[$];
  string tag_q[$];

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] SMIN = 64'h8000_0000_0000_0000;

  always #10 clk = ~clk;

  cmp128_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo), .imm(imm),
    .use_imm(use_imm), .cond(cond), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .taken(taken)
  );

  function automatic logic model(input logic [127:0] a, input logic [127:0] b,
                                 input logic [2:0] c);
    case (c)
      3'b000: return a == b;
      3'b001: return a != b;
      3'b100: return $signed(a) < $signed(b);
      3'b101: return $signed(a) >= $signed(b);
      3'b110: return a < b;
      3'b111: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [127:0] a, input logic [127:0] b,
                      input logic [11:0] im, input logic ui,
                      input logic [2:0] c, input string tag);
    logic [127:0] bv;
    bit fired = 1'b0;
    bv = ui ? {{116{im[11]}}, im} : b;
    @(negedge clk);
    a_hi = a[127:64]; a_lo = a[63:0]; b_hi = b[127:64]; b_lo = b[63:0];
    imm = im; use_imm = ui; cond = c; in_valid = 1'b1;
    while (!fired) begin
      #1;
      if (in_ready) begin
        fired = 1'b1;
        exp_q.push_back(model(a, bv, c));
        tag_q.push_back(tag);
      end
      @(posedge clk);
      if (!fired) @(negedge clk);
    end
    #1 in_valid = 1'b0;
  endtask

  // Back-pressure generator
  always @(negedge clk) out_ready = bp_en ? ($urandom % 3 != 0) : 1'b1;

  // Monitor / scoreboard
  logic held = 1'b0;
  logic held_bit;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (held) check(out_valid && result[0] == held_bit, "R10 hold",
                      {127'b0, result[0]}, {127'b0, held_bit});
      held = out_valid && !out_ready;
      held_bit = result[0];
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected output", result, '0);
        end else begin
          logic e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(result[0] == e, t, result, {127'b0, e});
          check(result[127:1] == '0 && taken == result[0], "R6",
                {result[127:1], taken}, {127'b0, result[0]});
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [63:0] pick();
    case ($urandom % 6)
      0: return '0;
      1: return 64'd1;
      2: return ONES;
      3: return SMIN;
      4: return SMIN - 1;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    #2 check(!out_valid && in_ready, "R1 reset", {126'b0, out_valid, in_ready}, 128'b01);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send({64'h5, 64'h7}, {64'h5, 64'h7}, 0, 0, 3'b000, "R2 equal");
    send({64'h5, 64'h7}, {64'h6, 64'h7}, 0, 0, 3'b000, "R2 hi differs");
    send({64'h5, 64'h7}, {64'h5, 64'h8}, 0, 0, 3'b001, "R3 lo differs");
    send({64'h5, 64'h7}, {64'h5, 64'h7}, 0, 0, 3'b001, "R3 same");
    send({ONES, ONES}, 128'd1, 0, 0, 3'b100, "R4 -1 < 1");
    send({SMIN, 64'd0}, {ONES, ONES}, 0, 0, 3'b100, "R4 min < -1");
    send({SMIN - 1, ONES}, {SMIN, 64'd0}, 0, 0, 3'b101, "R4 max >= min");
    send({ONES, ONES}, 128'd1, 0, 0, 3'b110, "R5 max ltu 1");
    send(128'd1, {ONES, ONES}, 0, 0, 3'b110, "R5 1 ltu max");
    send({64'd3, 64'd0}, {64'd3, 64'd0}, 0, 0, 3'b111, "R5 geu equal");
    send(128'd0, 0, 12'hFFF, 1, 3'b110, "R7 0 ltu sext(-1)");
    send(128'd0, 0, 12'hFFF, 1, 3'b100, "R7 0 lt -1");
    send({ONES, ONES}, 0, 12'h800, 1, 3'b100, "R7 -1 lt -2048");
    send(128'd100, 0, 12'h7FF, 1, 3'b110, "R7 100 ltu 2047");
    send({ONES, ONES}, 0, 12'hFFF, 1, 3'b000, "R7 eq sext");
    send(128'd0, 128'd1, 0, 0, 3'b010, "R8 code 2");
    send(128'd0, 128'd1, 0, 0, 3'b011, "R8 code 3");
    send({64'd1, 64'd0}, 128'd1, 0, 0, 3'b001, "R9 borrow ne");
    send({64'd1, 64'd0}, 128'd1, 0, 0, 3'b110, "R9 borrow ltu");
    send({64'd1, 64'd0}, {64'd0, ONES}, 0, 0, 3'b100, "R9 borrow lt");

    bp_en = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [2:0] c;
      c = 3'($urandom);
      send({pick(), pick()}, {pick(), pick()}, 12'($urandom), 1'($urandom % 4 == 0),
           c, "R10 random stream");
    end
    bp_en = 1'b0;

    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule